// File: doc/BRIEF.md
# Four-Channel Phase-Coherent Oscillator Core

This block runs four numerically controlled oscillator channels from one system clock. Each channel keeps three active settings. The first is a 32-bit frequency step. The second is a 14-bit phase shift. The third is a 10-bit amplitude scale with its own enable. On every clock edge each channel adds its frequency step to a 32-bit phase accumulator. The upper 14 bits of the accumulator, shifted by the phase offset, form a phase code for a sine lookup further downstream. A separate amplitude code goes to the converter. The output frequency of a channel is step × f_clk / 2^32.

Settings are staged on plain input buses. They become active only on a clock edge where the update strobe is high. A per-channel mask selects which channels take the staged words on that edge. The phase and amplitude outputs form a free-running stream with one new sample per clock. There is no valid/ready handshake and no back-pressure. Stalling one channel's accumulator would break the phase alignment between channels, so a consumer that cannot keep up must decimate downstream. A synchronous reset clears every channel at once, so all channels restart phase-aligned.

Top module: `dds_quad_core`

## Requirements
- R1: The frequency step, phase offset, amplitude scale and amplitude enable of channel c are captured only on an edge where `upd_i` is 1 and `upd_mask_i[c]` is 1. On every other edge they hold their value, whatever the staged inputs carry.
- R2: On each edge out of reset, a channel's accumulator advances by its active frequency step modulo 2^32. A step loaded on an edge is first used on the following edge; the edge that loads it still adds the previous step.
- R3: `phase_o` of a channel equals (accumulator bits [31:18] + phase offset) modulo 2^14. It is registered one edge after the accumulator.
- R4: With the amplitude enable at 1, `amp_o` of a channel equals (1023 × scale) >> 10, where 1023 is the full-scale code. It becomes valid on the second edge after the load.
- R5: With the amplitude enable at 0, `amp_o` is the full-scale code 1023, whatever the scale value is.
- R6: While `rst` is high, all accumulators, active settings and outputs are cleared to zero. `rst` overrides an update strobe on the same edge.
- R7: Channels loaded with identical settings on the same edge after reset produce identical phase codes on every following cycle.
- R8: Channel c occupies bits [c*W +: W] of each flat per-channel bus, where W is that field's width. Bit c of `upd_mask_i` and `amen_i` belongs to channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by all channels |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Update strobe for staged settings |
| upd_mask_i | input | 4 | Channels that accept the update |
| ftw_i | input | 128 | Staged 32-bit frequency steps |
| ofs_i | input | 56 | Staged 14-bit phase offsets |
| asf_i | input | 40 | Staged 10-bit amplitude scales |
| amen_i | input | 4 | Staged amplitude enables (1 = scaled, 0 = full scale) |
| phase_o | output | 56 | 14-bit phase codes per channel |
| amp_o | output | 40 | 10-bit amplitude codes per channel |

## Verification
Two pairs of actions can fall on the same edge. In the first, an update strobe lands on an edge where the accumulator also steps. The bench runs a channel at one step for several edges, loads a step four times larger on the next edge, and then checks the phase code two edges later. That code shows whether the loading edge still added the old step. In the second, reset and an update strobe are driven on the same edge. The bench then confirms at the outputs that no setting survived: the phase stays at zero and the amplitude sits at full scale.

// File: rtl/dds_quad_pkg.sv
package dds_quad_pkg;
  parameter int unsigned DDS_NCH   = 4;
  parameter int unsigned DDS_ACC_W = 32;
  parameter int unsigned DDS_OFS_W = 14;
  parameter int unsigned DDS_ASF_W = 10;

  typedef enum logic {
    AMP_BYPASS = 1'b0,
    AMP_SCALED = 1'b1
  } amp_mode_e;
endpackage

// File: rtl/dds_ctrl_latch.sv
module dds_ctrl_latch
  import dds_quad_pkg::*;
#(
  parameter int unsigned ACC_W = DDS_ACC_W,
  parameter int unsigned OFS_W = DDS_OFS_W,
  parameter int unsigned ASF_W = DDS_ASF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [ACC_W-1:0] ftw_d,
  input  logic [OFS_W-1:0] ofs_d,
  input  logic [ASF_W-1:0] asf_d,
  input  amp_mode_e        mode_d,
  output logic [ACC_W-1:0] ftw_q,
  output logic [OFS_W-1:0] ofs_q,
  output logic [ASF_W-1:0] asf_q,
  output amp_mode_e        mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_q  <= '0;
      ofs_q  <= '0;
      asf_q  <= '0;
      mode_q <= AMP_BYPASS;
    end else if (load_i) begin
      ftw_q  <= ftw_d;
      ofs_q  <= ofs_d;
      asf_q  <= asf_d;
      mode_q <= mode_d;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(ftw_q) && $stable(ofs_q) && $stable(asf_q) && $stable(mode_q))); // R1
endmodule

// File: rtl/dds_phase_path.sv
module dds_phase_path
  import dds_quad_pkg::*;
#(
  parameter int unsigned ACC_W = DDS_ACC_W,
  parameter int unsigned OFS_W = DDS_OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw_q,
  input  logic [OFS_W-1:0] ofs_q,
  output logic [OFS_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;
  logic [OFS_W-1:0] acc_top;

  assign acc_top = acc_q[ACC_W-1 -: OFS_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_o <= '0;
    end else begin
      acc_q   <= acc_q + ftw_q;
      phase_o <= acc_top + ofs_q;
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc_q == '0 && phase_o == '0)); // R6
endmodule

// File: rtl/dds_amp_path.sv
module dds_amp_path
  import dds_quad_pkg::*;
#(
  parameter int unsigned ASF_W = DDS_ASF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ASF_W-1:0] asf_q,
  input  amp_mode_e        mode_q,
  output logic [ASF_W-1:0] amp_o
);
  localparam logic [ASF_W-1:0] FULL = '1;
  localparam int unsigned PW = 2 * ASF_W;

  logic [PW-1:0]    prod;
  logic [ASF_W-1:0] amp_s1;

  assign prod = {{ASF_W{1'b0}}, FULL} * {{ASF_W{1'b0}}, asf_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_s1 <= '0;
      amp_o  <= '0;
    end else begin
      amp_s1 <= (mode_q == AMP_SCALED) ? prod[PW-1:ASF_W] : FULL;
      amp_o  <= amp_s1;
    end
  end

  AST_AMP_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == AMP_BYPASS) |=> ##1 (amp_o == FULL)); // R5
  AST_AMP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (mode_q == AMP_SCALED) |=> (amp_s1 <= $past(asf_q))); // R4
endmodule

// File: rtl/dds_quad_core.sv
module dds_quad_core
  import dds_quad_pkg::*;
#(
  parameter int unsigned NCH   = DDS_NCH,
  parameter int unsigned ACC_W = DDS_ACC_W,
  parameter int unsigned OFS_W = DDS_OFS_W,
  parameter int unsigned ASF_W = DDS_ASF_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_i,
  input  logic [NCH-1:0]       upd_mask_i,
  input  logic [NCH*ACC_W-1:0] ftw_i,
  input  logic [NCH*OFS_W-1:0] ofs_i,
  input  logic [NCH*ASF_W-1:0] asf_i,
  input  logic [NCH-1:0]       amen_i,
  output logic [NCH*OFS_W-1:0] phase_o,
  output logic [NCH*ASF_W-1:0] amp_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ACC_W-1:0] ftw_q;
    logic [OFS_W-1:0] ofs_q;
    logic [ASF_W-1:0] asf_q;
    amp_mode_e        mode_q;
    logic             load;

    assign load = upd_i & upd_mask_i[c];

    dds_ctrl_latch #(.ACC_W(ACC_W), .OFS_W(OFS_W), .ASF_W(ASF_W)) u_cfg (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .ftw_d  (ftw_i[c*ACC_W +: ACC_W]),
      .ofs_d  (ofs_i[c*OFS_W +: OFS_W]),
      .asf_d  (asf_i[c*ASF_W +: ASF_W]),
      .mode_d (amp_mode_e'(amen_i[c])),
      .ftw_q  (ftw_q),
      .ofs_q  (ofs_q),
      .asf_q  (asf_q),
      .mode_q (mode_q)
    );

    dds_phase_path #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_ph (
      .clk     (clk),
      .rst     (rst),
      .ftw_q   (ftw_q),
      .ofs_q   (ofs_q),
      .phase_o (phase_o[c*OFS_W +: OFS_W])
    );

    dds_amp_path #(.ASF_W(ASF_W)) u_amp (
      .clk    (clk),
      .rst    (rst),
      .asf_q  (asf_q),
      .mode_q (mode_q),
      .amp_o  (amp_o[c*ASF_W +: ASF_W])
    );
  end
endmodule

// File: tb/dds_quad_core_tb.sv
`timescale 1ns/1ps
module dds_quad_core_tb;
  localparam int NCH = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd = 1'b0;
  logic [NCH-1:0] msk = '0;
  logic [NCH*32-1:0] ftw = '0;
  logic [NCH*14-1:0] ofs = '0;
  logic [NCH*10-1:0] asf = '0;
  logic [NCH-1:0] amen = '0;
  logic [NCH*14-1:0] phase;
  logic [NCH*10-1:0] amp;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dds_quad_core u_dut (
    .clk(clk), .rst(rst), .upd_i(upd), .upd_mask_i(msk),
    .ftw_i(ftw), .ofs_i(ofs), .asf_i(asf), .amen_i(amen),
    .phase_o(phase), .amp_o(amp)
  );

  typedef struct packed {
    logic [31:0] f;
    logic [13:0] o;
    logic [9:0]  a;
    logic        e;
    logic [15:0] k;
    logic [13:0] xp;
    logic [9:0]  xa;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{32'h0004_0000, 14'd5,      10'd512,  1'b1, 16'd10,  14'd14,     10'd511},
    '{32'h8000_0000, 14'h3FFF,   10'd1023, 1'b1, 16'd5,   14'h3FFF,   10'd1022},
    '{32'h4000_0000, 14'h1800,   10'd0,    1'b1, 16'd4,   14'h0800,   10'd0},
    '{32'h0000_1000, 14'd0,      10'd300,  1'b0, 16'd100, 14'd1,      10'd1023},
    '{32'h0123_4567, 14'h0010,   10'd100,  1'b1, 16'd3,   14'h00A1,   10'd99}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobe(input logic [NCH-1:0] m);
    upd = 1'b1; msk = m;
    @(negedge clk);
    upd = 1'b0; msk = '0;
  endtask

  task automatic set_ch(input int c, input logic [31:0] f, input logic [13:0] o,
                        input logic [9:0] a, input logic e);
    ftw[c*32 +: 32] = f; ofs[c*14 +: 14] = o; asf[c*10 +: 10] = a; amen[c] = e;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R6: outputs cleared while reset is held
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(phase[c*14 +: 14] == 0, "R6 reset phase", phase[c*14 +: 14], 0);
      chk(amp[c*10 +: 10] == 0, "R6 reset amp", amp[c*10 +: 10], 0);
    end

    // R1 R3 R4 R5 R8: vector table, one channel loaded per entry
    foreach (TBL[i]) begin
      int ch;
      ch = i % NCH;
      do_reset();
      for (int c = 0; c < NCH; c++) set_ch(c, 32'h1111_1111, 14'h0AA, 10'd7, 1'b1);
      set_ch(ch, TBL[i].f, TBL[i].o, TBL[i].a, TBL[i].e);
      strobe(NCH'(1) << ch);
      repeat (int'(TBL[i].k)) @(negedge clk);
      chk(phase[ch*14 +: 14] == TBL[i].xp, "R3 phase", phase[ch*14 +: 14], TBL[i].xp);
      chk(amp[ch*10 +: 10] == TBL[i].xa, TBL[i].e ? "R4 amp" : "R5 amp",
          amp[ch*10 +: 10], TBL[i].xa);
      for (int c = 0; c < NCH; c++) if (c != ch) begin
        chk(phase[c*14 +: 14] == 0, "R8 other phase", phase[c*14 +: 14], 0);
        chk(amp[c*10 +: 10] == 10'd1023, "R1 other amp", amp[c*10 +: 10], 1023);
      end
    end

    // R1: strobe with empty mask and input changes without strobe are ignored
    do_reset();
    for (int c = 0; c < NCH; c++) set_ch(c, 32'h0100_0000, 14'd9, 10'd3, 1'b1);
    strobe('0);
    for (int c = 0; c < NCH; c++) set_ch(c, 32'h0200_0000, 14'd4, 10'd8, 1'b1);
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(phase[c*14 +: 14] == 0, "R1 ignored phase", phase[c*14 +: 14], 0);
      chk(amp[c*10 +: 10] == 10'd1023, "R1 ignored amp", amp[c*10 +: 10], 1023);
    end

    // R2: strobe and accumulation on the same edge; old step used on load edge
    do_reset();
    set_ch(1, 32'h0004_0000, 14'd0, 10'd0, 1'b0);
    strobe(4'b0010);
    repeat (4) @(negedge clk);
    set_ch(1, 32'h0010_0000, 14'd0, 10'd0, 1'b0);
    strobe(4'b0010);
    repeat (2) @(negedge clk);
    chk(phase[1*14 +: 14] == 14'd9, "R2 same-edge step", phase[1*14 +: 14], 9);

    // R7: identical settings give identical phases on all channels
    do_reset();
    for (int c = 0; c < NCH; c++) set_ch(c, 32'h0123_4567, 14'd0, 10'd0, 1'b0);
    strobe('1);
    repeat (7) @(negedge clk);
    for (int c = 0; c < NCH; c++)
      chk(phase[c*14 +: 14] == 14'h1B4, "R7 aligned phase", phase[c*14 +: 14], 14'h1B4);

    // R6: reset overrides a strobe on the same edge
    @(negedge clk);
    rst = 1'b1;
    for (int c = 0; c < NCH; c++) set_ch(c, 32'h0800_0000, 14'd33, 10'd5, 1'b1);
    upd = 1'b1; msk = '1;
    @(negedge clk);
    rst = 1'b0; upd = 1'b0; msk = '0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(phase[c*14 +: 14] == 0, "R6 reset beats strobe phase", phase[c*14 +: 14], 0);
      chk(amp[c*10 +: 10] == 10'd1023, "R6 reset beats strobe amp", amp[c*10 +: 10], 1023);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule